// File: doc/BRIEF.md
# 128-bit Vector Shift Unit

This block shifts a 128-bit vector in a single registered stage. It has two kinds of shift. The first moves the whole vector left or right by a scalar count from 0 to 127, either logically or arithmetically. The second gives each of the sixteen bytes its own shift amount of 0 to 7 bits. In that per-byte mode, the bits that enter a byte come from the adjacent byte of the source instead of being zeros.

The numbering is most-significant first. Byte 0 is bits 127:120, and byte 15 is bits 7:0. The upper doubleword is bits 127:64. A caller presents the source, the count or the amount vector, and an operation code with a valid strobe. The result appears one clock later with its own valid flag.

Top module: `vshift128`

## Requirements
- R1: Bit 127 is the most significant bit. Byte i occupies bits [127-8i : 120-8i], so byte 0 is the top byte and byte 15 is the bottom byte.
- R2: Op 3'd0 shifts the whole vector left by `count` (0..127) and fills with zeros. A count of 0 returns the source unchanged, and a count of 64 or more leaves bits 63:0 zero.
- R3: Op 3'd1 shifts the whole vector right by `count` and fills with zeros from the top.
- R4: Op 3'd2 shifts the whole vector right by `count` and fills with copies of source bit 127. For a count of 64 or more, bits 127:64 are all copies of that bit.
- R5: In the per-byte ops, byte i shifts by bits [2:0] of byte i of `amt`, which are bits [122-8i : 120-8i]. The upper five bits of each amount byte have no effect.
- R6: Op 3'd4 shifts each byte left. The vacated low bits of byte i take the top bits of source byte i+1, and byte 15 takes zeros.
- R7: Op 3'd5 shifts each byte right. The vacated high bits of byte i take the low bits of source byte i-1, and byte 0 takes zeros.
- R8: Op 3'd6 matches op 3'd5 except for byte 0, which is filled with copies of its own bit 7.
- R9: Op codes 3'd3 and 3'd7 return the source unchanged.
- R10: `out_valid` equals `in_valid` of the previous clock. Synchronous active-high `rst` clears `out_valid` and `result` to zero.
- R11: `result` updates only on clocks where `in_valid` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| op | input | 3 | Operation code |
| src | input | 128 | Source vector |
| count | input | 7 | Whole-vector shift count |
| amt | input | 128 | Per-byte shift amounts |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Shifted vector |

## Verification
The bench targets counts of 0, 63, 64, 65 and 127 in every whole-vector op. A design that swapped doublewords wrongly, or that sign-filled only one half of the vector, would give the wrong result across the 64-bit seam. In the per-byte ops, the bench sets junk in the upper amount bits and uses an all-ones source at both end bytes. A design that decoded too many amount bits, or that pulled fill bits from the wrong neighbour, would leak bits into the end bytes. The same stimulus also exposes a design that extended the per-byte arithmetic fill past byte 0. Gaps in `in_valid` show whether the design wrongly updates `result` while the strobe is low.

// File: rtl/vshift128.sv
module vshift128 #(
  parameter int VW = 128,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic [127:0]    src,
  input  logic [6:0]      count,
  input  logic [127:0]    amt,
  output logic            out_valid,
  output logic [127:0]    result
);
  localparam int NB = VW / BW;
  localparam int HW = VW / 2;

  logic [VW-1:0] sll_v, srl_v, sra_v, byl_v, byr_v, bya_v, nxt;

  assign sll_v = src << count;
  assign srl_v = src >> count;
  assign sra_v = VW'($signed(src) >>> count);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam int HI = VW - 1 - BW * g;
    logic [BW-1:0]   cur, below, above, above_a;
    logic [2:0]      sh;
    logic [2*BW-1:0] lw, rw, aw;
    assign cur = src[HI -: BW];
    assign sh  = amt[HI-BW+1 +: 3];
    if (g == NB - 1) begin : g_last
      assign below = '0;
    end else begin : g_mid
      assign below = src[HI-BW -: BW];
    end
    if (g == 0) begin : g_first
      assign above   = '0;
      assign above_a = {BW{cur[BW-1]}};
    end else begin : g_rest
      assign above   = src[HI+BW -: BW];
      assign above_a = above;
    end
    assign lw = {cur, below} << sh;
    assign rw = {above, cur} >> sh;
    assign aw = {above_a, cur} >> sh;
    assign byl_v[HI -: BW] = lw[2*BW-1 -: BW];
    assign byr_v[HI -: BW] = rw[BW-1:0];
    assign bya_v[HI -: BW] = aw[BW-1:0];
  end

  always_comb begin
    case (op)
      3'd0:    nxt = sll_v;
      3'd1:    nxt = srl_v;
      3'd2:    nxt = sra_v;
      3'd4:    nxt = byl_v;
      3'd5:    nxt = byr_v;
      3'd6:    nxt = bya_v;
      default: nxt = src;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  assert_valid_rise_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  assert_zero_count_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && count == 7'd0) |=> result == $past(src));
  assert_low_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && count[6]) |=> result[HW-1:0] == '0);
  assert_sign_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd2 && count[6]) |=> result[VW-1:HW] == {HW{$past(src[VW-1])}});
  assert_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 3'd3 || op == 3'd7)) |=> result == $past(src));
endmodule

// File: tb/vshift128_tb.sv
module vshift128_tb_top;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [127:0] src = '0, amt = '0;
  logic [6:0] count = '0;
  logic out_valid;
  logic [127:0] result;
  int total = 0, bad = 0, cyc = 0;
  logic [127:0] held;

  always #2 clk = ~clk;

  vshift128 dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src(src),
                   .count(count), .amt(amt), .out_valid(out_valid), .result(result));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad = bad + 1;
      $display("FAIL watchdog R10 actual=%0d expected<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  function automatic logic [7:0] get_byte(input logic [127:0] v, input int i);
    return v[127 - 8*i -: 8];
  endfunction

  function automatic logic [127:0] model(input logic [2:0] o, input logic [127:0] s,
                                         input int c, input logic [127:0] a);
    logic [127:0] r = '0;
    case (o)
      3'd0: for (int b = 0; b < 128; b++) r[b] = (b - c >= 0) ? s[b - c] : 1'b0;
      3'd1: for (int b = 0; b < 128; b++) r[b] = (b + c <= 127) ? s[b + c] : 1'b0;
      3'd2: for (int b = 0; b < 128; b++) r[b] = (b + c <= 127) ? s[b + c] : s[127];
      3'd4, 3'd5, 3'd6: begin
        for (int i = 0; i < 16; i++) begin
          int e0, eu, ed, sh, v;
          e0 = int'(get_byte(s, i));
          sh = int'(get_byte(a, i)) % 8;
          ed = (i < 15) ? int'(get_byte(s, i + 1)) : 0;
          eu = (i > 0) ? int'(get_byte(s, i - 1)) : ((o == 3'd6 && e0 >= 128) ? 255 : 0);
          if (o == 3'd4) v = (((e0 * 256 + ed) << sh) >> 8) % 256;
          else v = ((eu * 256 + e0) >> sh) % 256;
          r[127 - 8*i -: 8] = 8'(v);
        end
      end
      default: r = s;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [127:0] s, input int c,
                     input logic [127:0] a, input string req);
    logic [127:0] e;
    e = model(o, s, c, a);
    @(negedge clk);
    op = o; src = s; count = 7'(c); amt = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " result"}, result, e);
    check("R10 valid", {127'd0, out_valid}, 128'd1);
  endtask

  initial begin
    logic [127:0] pat;
    int seed;
    seed = $urandom(32'd77);
    pat = 128'h0123456789ABCDEF_FEDCBA9876543210;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {127'd0, out_valid}, 128'd0);
    check("R10 reset result", result, 128'd0);
    rst = 1'b0;

    foreach (pat[k]) if (k < 5) begin
      int cs[5] = '{0, 63, 64, 65, 127};
      for (int o = 0; o < 3; o++) run(3'(o), pat | 128'h1 << 127, cs[k], '0, tag(3'(o)));
    end
    run(3'd0, pat, 0, '0, "R2 zero count");
    run(3'd2, {1'b0, pat[126:0]}, 100, '0, "R4 positive");
    run(3'd1, 128'h1 << 127, 0, '0, "R1 msb position");
    run(3'd4, {8'h01, 120'd0}, 0, {8'h07, 120'd0}, "R1 byte0 left");
    run(3'd4, {128{1'b1}}, 0, {16{8'hFB}}, "R5 upper amount bits");
    run(3'd4, {128{1'b1}}, 0, {16{8'hF8}}, "R5 zero low amount");
    run(3'd5, {128{1'b1}}, 0, {16{8'h07}}, "R7 byte0 zero fill");
    run(3'd6, {128{1'b1}}, 0, {16{8'h07}}, "R8 byte0 sign fill");
    run(3'd6, {8'h80, 8'h00, 112'd0}, 0, {16{8'h03}}, "R8 only byte0 signed");
    run(3'd4, {128{1'b1}}, 0, {16{8'h05}}, "R6 byte15 zero fill");
    run(3'd3, pat, 9, pat, "R9 op3");
    run(3'd7, pat, 9, pat, "R9 op7");

    for (int n = 0; n < 400; n++) begin
      logic [2:0] o;
      logic [127:0] s, a;
      o = 3'($urandom);
      s = {$urandom, $urandom, $urandom, $urandom};
      a = {$urandom, $urandom, $urandom, $urandom};
      run(o, s, int'($urandom % 128), a, tag(o));
      if (n % 50 == 0) begin
        held = result;
        @(negedge clk);
        src = ~src; op = 3'd1; count = 7'd3;
        @(negedge clk);
        check("R11 hold", result, held);
        check("R10 idle valid", {127'd0, out_valid}, 128'd0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule